// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the control state machine of an I2C master. Software writes a set of control bits: start, stop, repeat mode, direction and address width. It pulses a separate request when the next received byte should be refused. Each accepted request becomes a series of byte-level commands to a bit engine: START, one or two address bytes, a counted or open-ended run of data bytes, and STOP. The bit engine handles the wire timing. It reports each finished command with a done pulse, the acknowledge bit it saw, and any byte it received.

The block watches the bus-busy input, the acknowledge responses and the arbitration-loss indication, and raises one-cycle status pulses. A lost arbitration, or a start request while another master holds the bus, ends the transfer. The block then drops to slave-receiver mode.

Top module: `i2cm_sequencer`

## Requirements
- R1: With repeat off, start and stop set, the bit engine receives START, the address byte(s), exactly N data bytes (N = `byte_count`), then STOP. Command codes on `be_cmd` are 0 START, 1 STOP, 2 WRITE, 3 READ. `be_cmd` and `be_wdata` hold steady while `be_cmd_valid` is high and no done has arrived. Each WRITE data command raises `flag_xrdy` once.
- R2: A `byte_count` of zero means 2^CNT_W data bytes.
- R3: With repeat on and start set, data bytes run without limit until a stop write ends them with STOP, or a start write inserts a repeated START and address. `flag_ardy` pulses once per data byte in repeat mode.
- R4: A stop-only write issues a single STOP. A write with neither start nor stop produces no command, and so does the combination repeat, start and stop all set.
- R5: A start request while idle and `bus_busy` is high issues no command. It pulses `flag_al`, clears `master_on` and `stop_armed`, and sets `slave_rx`.
- R6: `arb_lost` during START, address or data aborts the transfer at once. `be_cmd_valid` drops, `flag_al` pulses, `master_on` and `stop_armed` clear, and `slave_rx` sets.
- R7: In 7-bit mode the address byte is {slave_addr[6:0], rw}, where rw = 1 for a read (`ctl_transmit` = 0).
- R8: In 10-bit mode two address bytes are sent: {5'b11110, slave_addr[9:8], rw}, then slave_addr[7:0].
- R9: `be_ack_out` (0 = ACK, 1 = NACK) is 1 once `nack_req` has pulsed. It stays 1 until the next READ completes, then returns to 0.
- R10: A NACK (`be_ack_in` = 1) on any written byte, address or data, pulses `flag_nack`, and STOP is the next command.
- R11: When STOP completes, `flag_scd` pulses for one cycle and `master_on` clears.
- R12: A counted transfer with start but no stop keeps `master_on` high after its last byte and issues no STOP. A following start is accepted as a repeated START even while `bus_busy` is high.
- R13: Each completed READ pulses `flag_rrdy`, with `rx_data` holding the byte the bit engine returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start request bit |
| ctl_stop | input | 1 | Stop request bit |
| ctl_repeat | input | 1 | Repeat (uncounted) mode |
| ctl_transmit | input | 1 | 1 = master transmitter, 0 = master receiver |
| ctl_ten_bit | input | 1 | 1 = 10-bit addressing |
| nack_req | input | 1 | Pulse: refuse the next received byte |
| slave_addr | input | 10 | Target address |
| byte_count | input | CNT_W | Data byte count, 0 means 2^CNT_W |
| tx_byte | input | 8 | Next byte to transmit |
| bus_busy | input | 1 | Bus held by some master |
| arb_lost | input | 1 | Bit engine lost arbitration |
| be_cmd_valid | output | 1 | Command pending for bit engine |
| be_cmd | output | 2 | Command code |
| be_wdata | output | 8 | Byte to send |
| be_ack_out | output | 1 | Ack bit to send after a read |
| be_done | input | 1 | Command finished |
| be_ack_in | input | 1 | Ack bit seen after a write |
| be_rdata | input | 8 | Byte read |
| master_on | output | 1 | Block owns the bus as master |
| stop_armed | output | 1 | A STOP is scheduled |
| slave_rx | output | 1 | Fell back to slave receiver |
| rx_data | output | 8 | Last received byte |
| flag_ardy | output | 1 | Pulse: repeat-mode byte done |
| flag_nack | output | 1 | Pulse: NACK received |
| flag_al | output | 1 | Pulse: arbitration lost |
| flag_scd | output | 1 | Pulse: STOP completed |
| flag_xrdy | output | 1 | Pulse: transmit byte taken |
| flag_rrdy | output | 1 | Pulse: byte received |

## Verification
The hardest case to reach from the ports is a loss of arbitration in the middle of a command. No ordinary response sequence causes it. The bench's bit-engine model can be frozen so that it never completes the pending START. An arbitration-loss pulse is then injected and the abort is observed. The repeat-mode case with a repeated START is also hard to reach: the start write must land while data bytes are streaming. The bench waits on the count of `flag_ardy` pulses before issuing each write, then checks the logged command stream.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bcmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_START, ST_ADDR_HI, ST_ADDR_LO, ST_DATA, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2cm_addr_fmt.sv
module i2cm_addr_fmt
  import i2cm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten_bit,
  input  logic              rd,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] second_byte
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    if (ten_bit) first_byte = {TEN_PREFIX, addr[9:8], rd};
    else         first_byte = {addr[6:0], rd};
    second_byte = addr[7:0];
  end
endmodule

// File: rtl/i2cm_xfer_count.sv
module i2cm_xfer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] ONE  = FULL_W'(1);
  localparam logic [FULL_W-1:0] WRAP = {1'b1, {CNT_W{1'b0}}};

  logic [FULL_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= (load_val == '0) ? WRAP : {1'b0, load_val};
    end else if (dec && remain != '0) begin
      remain <= remain - ONE;
    end
  end

  assign last = (remain == ONE);
endmodule

// File: rtl/i2cm_sequencer.sv
module i2cm_sequencer
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_start,
  input  logic              ctl_stop,
  input  logic              ctl_repeat,
  input  logic              ctl_transmit,
  input  logic              ctl_ten_bit,
  input  logic              nack_req,
  input  logic [9:0]        slave_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        tx_byte,
  input  logic              bus_busy,
  input  logic              arb_lost,
  output logic              be_cmd_valid,
  output logic [1:0]        be_cmd,
  output logic [7:0]        be_wdata,
  output logic              be_ack_out,
  input  logic              be_done,
  input  logic              be_ack_in,
  input  logic [7:0]        be_rdata,
  output logic              master_on,
  output logic              stop_armed,
  output logic              slave_rx,
  output logic [7:0]        rx_data,
  output logic              flag_ardy,
  output logic              flag_nack,
  output logic              flag_al,
  output logic              flag_scd,
  output logic              flag_xrdy,
  output logic              flag_rrdy
);
  seq_state_e state, state_n;
  bcmd_e      cmd_q;

  logic [ADDR_W-1:0] addr_q;
  logic tx_q, ten_q, rpt_q, stop_en_q;
  logic start_pend, stop_pend, nack_pend;
  logic cnt_last;
  logic [BYTE_W-1:0] addr_b0, addr_b1;

  logic req_start, req_stop_only, go_load, cnt_dec, issue, pend_set_ok;
  logic set_al, set_nack, set_ardy, set_rrdy, set_scd;

  function automatic logic is_cmd(seq_state_e s);
    return (s == ST_START) || (s == ST_ADDR_HI) || (s == ST_ADDR_LO) ||
           (s == ST_DATA)  || (s == ST_STOP);
  endfunction

  function automatic bcmd_e cmd_of(seq_state_e s, logic tx);
    case (s)
      ST_START: return BC_START;
      ST_STOP:  return BC_STOP;
      ST_DATA:  return tx ? BC_WRITE : BC_READ;
      default:  return BC_WRITE;
    endcase
  endfunction

  i2cm_addr_fmt u_addr (
    .addr        (addr_q),
    .ten_bit     (ten_q),
    .rd          (~tx_q),
    .first_byte  (addr_b0),
    .second_byte (addr_b1)
  );

  i2cm_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (go_load),
    .load_val (byte_count),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  always_comb begin
    state_n  = state;
    go_load  = 1'b0;
    cnt_dec  = 1'b0;
    set_al   = 1'b0;
    set_nack = 1'b0;
    set_ardy = 1'b0;
    set_rrdy = 1'b0;
    set_scd  = 1'b0;
    req_start     = ctl_wr && ctl_start && !(ctl_repeat && ctl_stop);
    req_stop_only = ctl_wr && ctl_stop && !ctl_start;
    case (state)
      ST_IDLE, ST_HOLD: begin
        if (req_start) begin
          if (state == ST_IDLE && bus_busy) set_al = 1'b1;
          else begin
            go_load = 1'b1;
            state_n = ST_START;
          end
        end else if (req_stop_only) begin
          state_n = ST_STOP;
        end
      end
      ST_START: begin
        if (arb_lost) begin
          set_al  = 1'b1;
          state_n = ST_IDLE;
        end else if (be_done) state_n = ST_ADDR_HI;
      end
      ST_ADDR_HI, ST_ADDR_LO: begin
        if (arb_lost) begin
          set_al  = 1'b1;
          state_n = ST_IDLE;
        end else if (be_done) begin
          if (be_ack_in) begin
            set_nack = 1'b1;
            state_n  = ST_STOP;
          end else if (state == ST_ADDR_HI && ten_q) state_n = ST_ADDR_LO;
          else state_n = ST_DATA;
        end
      end
      ST_DATA: begin
        if (arb_lost) begin
          set_al  = 1'b1;
          state_n = ST_IDLE;
        end else if (be_done) begin
          set_rrdy = !tx_q;
          set_ardy = rpt_q;
          cnt_dec  = !rpt_q;
          if (tx_q && be_ack_in) begin
            set_nack = 1'b1;
            state_n  = ST_STOP;
          end else if (rpt_q) begin
            if (stop_pend)       state_n = ST_STOP;
            else if (start_pend) state_n = ST_START;
          end else if (cnt_last) begin
            state_n = stop_en_q ? ST_STOP : ST_HOLD;
          end
        end
      end
      ST_STOP: begin
        if (be_done) begin
          set_scd = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    issue = is_cmd(state_n) && ((state_n != state) || be_done);
    pend_set_ok = ctl_wr && rpt_q && is_cmd(state) && (state != ST_STOP) &&
                  is_cmd(state_n) && (state_n != ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cmd_q        <= BC_START;
      be_cmd_valid <= 1'b0;
      be_wdata     <= '0;
      addr_q       <= '0;
      tx_q         <= 1'b0;
      ten_q        <= 1'b0;
      rpt_q        <= 1'b0;
      stop_en_q    <= 1'b0;
      start_pend   <= 1'b0;
      stop_pend    <= 1'b0;
      nack_pend    <= 1'b0;
      master_on    <= 1'b0;
      stop_armed   <= 1'b0;
      slave_rx     <= 1'b0;
      rx_data      <= '0;
      flag_ardy    <= 1'b0;
      flag_nack    <= 1'b0;
      flag_al      <= 1'b0;
      flag_scd     <= 1'b0;
      flag_xrdy    <= 1'b0;
      flag_rrdy    <= 1'b0;
    end else begin
      state        <= state_n;
      be_cmd_valid <= is_cmd(state_n);
      if (issue) begin
        cmd_q <= cmd_of(state_n, tx_q);
        case (state_n)
          ST_ADDR_HI: be_wdata <= addr_b0;
          ST_ADDR_LO: be_wdata <= addr_b1;
          ST_DATA:    be_wdata <= tx_q ? tx_byte : '1;
          default:    be_wdata <= '0;
        endcase
      end
      if (go_load) begin
        addr_q    <= slave_addr;
        tx_q      <= ctl_transmit;
        ten_q     <= ctl_ten_bit;
        rpt_q     <= ctl_repeat;
        stop_en_q <= ctl_stop && !ctl_repeat;
      end
      if (go_load || state_n == ST_STOP || state_n == ST_IDLE) begin
        start_pend <= 1'b0;
        stop_pend  <= 1'b0;
      end else if (state == ST_DATA && state_n == ST_START) begin
        start_pend <= 1'b0;
      end
      if (pend_set_ok) begin
        if (ctl_start) start_pend <= 1'b1;
        if (ctl_stop)  stop_pend  <= 1'b1;
      end
      if (nack_req) nack_pend <= 1'b1;
      else if (set_rrdy) nack_pend <= 1'b0;
      if (set_al || set_scd) master_on <= 1'b0;
      else if (go_load)      master_on <= 1'b1;
      if (set_al || set_scd) stop_armed <= 1'b0;
      else if ((go_load && ctl_stop && !ctl_repeat) || state_n == ST_STOP ||
               (pend_set_ok && ctl_stop)) stop_armed <= 1'b1;
      if (set_al)       slave_rx <= 1'b1;
      else if (go_load) slave_rx <= 1'b0;
      if (set_rrdy) rx_data <= be_rdata;
      flag_ardy <= set_ardy;
      flag_nack <= set_nack;
      flag_al   <= set_al;
      flag_scd  <= set_scd;
      flag_rrdy <= set_rrdy;
      flag_xrdy <= issue && state_n == ST_DATA && tx_q;
    end
  end

  assign be_cmd     = cmd_q;
  assign be_ack_out = nack_pend;
endmodule

// File: rtl/i2cm_sequencer_chk.sv
module i2cm_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic       ctl_start,
  input logic       ctl_stop,
  input logic       ctl_repeat,
  input logic       bus_busy,
  input logic       arb_lost,
  input logic       nack_req,
  input logic       be_cmd_valid,
  input logic [1:0] be_cmd,
  input logic [7:0] be_wdata,
  input logic       be_ack_out,
  input logic       be_done,
  input logic       be_ack_in,
  input logic       master_on,
  input logic       stop_armed,
  input logic       slave_rx,
  input logic       flag_al,
  input logic       flag_nack,
  input logic       flag_scd
);
  assert_cmd_steady_R1: assert property (@(posedge clk) disable iff (rst)
    (be_cmd_valid && !be_done && !arb_lost) |=>
      (be_cmd_valid && $stable(be_cmd) && $stable(be_wdata)));

  assert_no_activity_R4: assert property (@(posedge clk) disable iff (rst)
    (!master_on && !be_cmd_valid && ctl_wr &&
     (ctl_start ? (ctl_repeat && ctl_stop) : !ctl_stop)) |=> !be_cmd_valid);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
    (!master_on && !be_cmd_valid && bus_busy && ctl_wr && ctl_start &&
     !(ctl_repeat && ctl_stop)) |=> (flag_al && !be_cmd_valid));

  assert_al_state_R6: assert property (@(posedge clk) disable iff (rst)
    flag_al |-> (!master_on && !stop_armed && slave_rx && !be_cmd_valid));

  assert_nack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (be_cmd_valid && be_done && be_cmd == 2'd3 && be_ack_out && !nack_req && !arb_lost)
      |=> !be_ack_out);

  assert_nack_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (be_cmd_valid && be_done && be_cmd == 2'd2 && be_ack_in && !arb_lost)
      |=> (be_cmd_valid && be_cmd == 2'd1 && flag_nack));

  assert_stop_done_R11: assert property (@(posedge clk) disable iff (rst)
    (be_cmd_valid && be_done && be_cmd == 2'd1) |=>
      (flag_scd && !master_on && !be_cmd_valid));
endmodule

bind i2cm_sequencer i2cm_sequencer_chk u_chk (.*);

// File: tb/i2cm_sequencer_test.sv
module i2cm_sequencer_test;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_start = 0, ctl_stop = 0, ctl_repeat = 0;
  logic ctl_transmit = 0, ctl_ten_bit = 0, nack_req = 0;
  logic [9:0] slave_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] tx_byte = '0;
  logic bus_busy = 0, arb_lost = 0;
  logic be_cmd_valid, be_ack_out;
  logic [1:0] be_cmd;
  logic [7:0] be_wdata;
  logic be_done = 0, be_ack_in = 0;
  logic [7:0] be_rdata = '0;
  logic master_on, stop_armed, slave_rx;
  logic [7:0] rx_data;
  logic flag_ardy, flag_nack, flag_al, flag_scd, flag_xrdy, flag_rrdy;

  always #10 clk = ~clk;

  i2cm_sequencer #(.CNT_W(CW)) uut (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  int log_cmd [64];
  int log_dat [64];
  int log_ack [64];
  int log_n = 0;
  int exp_cmd [64];
  int exp_dat [64];
  int exp_ack [64];
  int exp_n = 0;
  int nack_at = -1;
  bit model_stall = 0;
  bit busy_m = 0;
  int wcnt = 0;
  int last_rd = 0;
  int ardy_cnt = 0, nack_cnt = 0, al_cnt = 0, scd_cnt = 0, xrdy_cnt = 0, rrdy_cnt = 0;

  // bit engine model: completes each command a few cycles after it appears
  always @(negedge clk) begin
    if (be_done) begin
      be_done = 0;
      be_ack_in = 0;
    end else if (be_cmd_valid && !model_stall) begin
      if (!busy_m) begin
        busy_m = 1;
        wcnt = 2;
      end else if (wcnt != 0) begin
        wcnt--;
      end else begin
        busy_m = 0;
        be_ack_in = (be_cmd == 2'd2 && log_n == nack_at);
        be_rdata = 8'($urandom);
        if (be_cmd == 2'd3) last_rd = be_rdata;
        if (log_n < 64) begin
          log_cmd[log_n] = be_cmd;
          log_dat[log_n] = be_wdata;
          log_ack[log_n] = be_ack_out;
          log_n++;
        end
        be_done = 1;
      end
    end else begin
      busy_m = 0;
    end
    if (flag_ardy) ardy_cnt++;
    if (flag_nack) nack_cnt++;
    if (flag_al)   al_cnt++;
    if (flag_scd)  scd_cnt++;
    if (flag_xrdy) xrdy_cnt++;
    if (flag_rrdy) rrdy_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_all();
    log_n = 0; exp_n = 0; nack_at = -1;
    ardy_cnt = 0; nack_cnt = 0; al_cnt = 0; scd_cnt = 0; xrdy_cnt = 0; rrdy_cnt = 0;
  endtask

  task automatic push(input int c, input int d, input int a);
    exp_cmd[exp_n] = c; exp_dat[exp_n] = d; exp_ack[exp_n] = a; exp_n++;
  endtask

  task automatic compare_log(input string req);
    check(log_n == exp_n, {req, " command count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_cmd[i] == exp_cmd[i], {req, " command code"}, log_cmd[i], exp_cmd[i]);
      if (exp_cmd[i] == 2)
        check(log_dat[i] == exp_dat[i], {req, " write byte"}, log_dat[i], exp_dat[i]);
      if (exp_cmd[i] == 3)
        check(log_ack[i] == exp_ack[i], {req, " read ack bit"}, log_ack[i], exp_ack[i]);
    end
  endtask

  task automatic do_cmd(input bit s, input bit p, input bit r, input bit tx, input bit ten);
    @(negedge clk);
    ctl_start = s; ctl_stop = p; ctl_repeat = r; ctl_transmit = tx; ctl_ten_bit = ten;
    ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic wait_quiet();
    for (int k = 0; k < 5000 && be_cmd_valid; k++) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic int addr_hi(input int a, input bit ten, input bit rd);
    return ten ? ((5'b11110 << 3) | (((a >> 8) & 3) << 1) | rd) : (((a & 7'h7f) << 1) | rd);
  endfunction

  task automatic push_header(input int a, input bit ten, input bit rd);
    push(0, 0, 0);
    push(2, addr_hi(a, ten, rd), 0);
    if (ten) push(2, a & 8'hff, 0);
  endtask

  task automatic counted(input int n, input bit tx, input bit ten, input int a, input int txb,
                         input bit stp);
    slave_addr = 10'(a);
    tx_byte = 8'(txb);
    byte_count = CW'(n);
    do_cmd(1, stp, 0, tx, ten);
    wait_quiet();
  endtask

  task automatic wait_ardy(input int n);
    for (int k = 0; k < 5000 && ardy_cnt < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check(!master_on && !be_cmd_valid && !slave_rx && !stop_armed, "R11 reset state",
          int'({master_on, be_cmd_valid, slave_rx, stop_armed}), 0);

    // random counted transfers, R1 R7 R8 R13
    for (int t = 0; t < 20; t++) begin
      int n, a, b;
      bit tx, ten;
      n = 1 + int'($urandom % 6);
      tx = 1'($urandom);
      ten = 1'($urandom);
      a = int'($urandom % 1024);
      b = int'($urandom % 256);
      clear_all();
      push_header(a, ten, !tx);
      for (int i = 0; i < n; i++) push(tx ? 2 : 3, b, 0);
      push(1, 0, 0);
      counted(n, tx, ten, a, b, 1);
      compare_log(ten ? "R8 R1 random" : "R7 R1 random");
      check(scd_cnt == 1 && !master_on, "R11 stop done", scd_cnt, 1);
      if (tx) check(xrdy_cnt == n, "R1 transmit ready count", xrdy_cnt, n);
      else begin
        check(rrdy_cnt == n, "R13 receive count", rrdy_cnt, n);
        check(rx_data == 8'(last_rd), "R13 received byte", rx_data, last_rd);
      end
    end

    // directed 10-bit read address
    clear_all();
    push(0, 0, 0); push(2, 8'hF5, 0); push(2, 8'hA5, 0); push(3, 0, 0); push(1, 0, 0);
    counted(1, 0, 1, 10'h2A5, 0, 1);
    compare_log("R8 ten-bit read");

    // count zero means 16
    clear_all();
    push_header(7'h31, 0, 0);
    for (int i = 0; i < 16; i++) push(2, 8'h5A, 0);
    push(1, 0, 0);
    counted(0, 1, 0, 7'h31, 8'h5A, 1);
    compare_log("R2 zero count");

    // repeat mode with stop
    clear_all();
    slave_addr = 10'h12; tx_byte = 8'h3C;
    do_cmd(1, 0, 1, 1, 0);
    wait_ardy(4);
    do_cmd(0, 1, 1, 1, 0);
    wait_quiet();
    begin
      int w = 0;
      for (int i = 0; i < log_n; i++) if (log_cmd[i] == 2) w++;
      check(w - 1 == ardy_cnt && ardy_cnt >= 4, "R3 ardy per byte", ardy_cnt, w - 1);
      check(log_n > 0 && log_cmd[log_n-1] == 1 && log_cmd[0] == 0, "R3 ends with stop",
            log_n > 0 ? log_cmd[log_n-1] : -1, 1);
    end

    // repeat mode with repeated start
    clear_all();
    do_cmd(1, 0, 1, 1, 0);
    wait_ardy(2);
    do_cmd(1, 0, 1, 1, 0);
    wait_ardy(5);
    do_cmd(0, 1, 1, 1, 0);
    wait_quiet();
    begin
      int s = 0;
      for (int i = 0; i < log_n; i++) if (log_cmd[i] == 0) s++;
      check(s == 2, "R3 repeated start count", s, 2);
      check(scd_cnt == 1, "R3 single stop", scd_cnt, 1);
    end

    // stop only
    clear_all();
    push(1, 0, 0);
    do_cmd(0, 1, 0, 1, 0);
    wait_quiet();
    compare_log("R4 stop only");
    check(scd_cnt == 1 && !master_on, "R11 stop only flag", scd_cnt, 1);

    // no activity: none, reserved
    clear_all();
    do_cmd(0, 0, 0, 1, 0);
    do_cmd(1, 1, 1, 1, 0);
    repeat (10) @(negedge clk);
    check(log_n == 0 && !master_on, "R4 no activity", log_n, 0);

    // start while bus busy
    clear_all();
    bus_busy = 1;
    do_cmd(1, 1, 0, 1, 0);
    repeat (10) @(negedge clk);
    bus_busy = 0;
    check(log_n == 0 && al_cnt == 1, "R5 busy start", al_cnt, 1);
    check(slave_rx && !master_on && !stop_armed, "R5 slave fallback",
          int'({slave_rx, master_on, stop_armed}), 4);

    // arbitration lost mid command
    clear_all();
    model_stall = 1;
    byte_count = 3;
    do_cmd(1, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    arb_lost = 1;
    @(negedge clk);
    arb_lost = 0;
    @(negedge clk);
    #1;
    check(al_cnt == 1 && !be_cmd_valid, "R6 abort", al_cnt, 1);
    check(slave_rx && !master_on && !stop_armed, "R6 slave fallback",
          int'({slave_rx, master_on, stop_armed}), 4);
    model_stall = 0;

    // slave NACK on second data byte
    clear_all();
    nack_at = 3;
    push_header(7'h22, 0, 0); push(2, 8'h11, 0); push(2, 8'h11, 0); push(1, 0, 0);
    counted(5, 1, 0, 7'h22, 8'h11, 1);
    compare_log("R10 data nack");
    check(nack_cnt == 1, "R10 nack flag", nack_cnt, 1);

    // slave NACK on address
    clear_all();
    nack_at = 1;
    push_header(7'h23, 0, 0); push(1, 0, 0);
    counted(2, 1, 0, 7'h23, 8'h11, 1);
    compare_log("R10 address nack");

    // receive NACK request then cleared
    clear_all();
    slave_addr = 10'h40; byte_count = 1;
    push_header(10'h40, 0, 1); push(3, 0, 1); push(1, 0, 0);
    do_cmd(1, 1, 0, 0, 0);
    nack_req = 1;
    @(negedge clk);
    nack_req = 0;
    wait_quiet();
    compare_log("R9 nack request");
    clear_all();
    push_header(10'h40, 0, 1); push(3, 0, 0); push(3, 0, 0); push(1, 0, 0);
    counted(2, 0, 0, 10'h40, 0, 1);
    compare_log("R9 request cleared");

    // counted without stop holds bus, then repeated start under busy
    clear_all();
    push_header(7'h15, 0, 0); push(2, 8'h77, 0); push(2, 8'h77, 0);
    counted(2, 1, 0, 7'h15, 8'h77, 0);
    compare_log("R12 hold");
    check(master_on && scd_cnt == 0, "R12 master kept", int'(master_on), 1);
    clear_all();
    bus_busy = 1;
    push_header(7'h15, 0, 0); push(2, 8'h77, 0); push(1, 0, 0);
    counted(1, 1, 0, 7'h15, 8'h77, 1);
    bus_busy = 0;
    compare_log("R12 restart from hold");
    check(al_cnt == 0 && !master_on, "R12 restart no loss", al_cnt, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule